// File: doc/BRIEF.md
# Fractional Vertical Total Sequencer

This block produces a vertical line count and a matching vertical front porch for every video frame. With a fixed pixel clock, a refresh rate whose ideal line count is not a whole number can be approached by alternating frame to frame between two adjacent totals, N and N+1. The choice of N or N+1 for each frame is read from a stored bit pattern of up to 128 frames, which repeats for as long as the rate stays in force.

A profile gives the integer total N, the pattern length and the pattern itself. Software loads a profile and pulses `rate_start`. That marks a rate change as pending. The pending change is taken at the next `frame_start` pulse, and the profile is captured at that moment. From then on, each `frame_start` advances the sequence. The outputs are registered, and a single-cycle `upd_o` strobe marks each new value. A profile whose computed total would be zero is refused with an error strobe, and the outputs are left as they were.

Top module: `vtot_frac_seq`

## Requirements
- R1: After reset, `vtotal_o`, `vfp_o`, `upd_o` and `err_o` are all zero.
- R2: A `rate_start` pulse makes a change pending. The change is applied at the next `frame_start`, and `upd_o` is high for exactly the one cycle after that `frame_start`. A `frame_start` with nothing pending and no active sequence gives no strobe and leaves the outputs unchanged.
- R3: The total for a frame is the profile's integer total, plus one when the pattern bit for that frame is 1. The first frame of a new rate uses pattern index 0.
- R4: Pattern index p reads `prof_pattern` bit 8*(p/8)+7-(p%8). Byte k occupies bits [8k+7:8k], and within each byte the bits are taken most significant first.
- R5: After the first frame, the pattern index advances by one on each applied frame and wraps to 0 on reaching the pattern length. The sequence therefore repeats with a period of the pattern length.
- R6: A pattern length of zero applies the integer total once. Later `frame_start` pulses then produce no update until the next rate change.
- R7: A pattern length above 128 is treated as 128.
- R8: `vfp_o` equals `base_vs_start` minus `base_vdisp`, plus the new total, minus `base_vtotal`, taken modulo 2^16.
- R9: When the computed total is zero, no update is made, `err_o` is high for the one cycle after that `frame_start`, and the change stays pending so that it is retried at the next `frame_start`.
- R10: The profile is captured when the change is taken. Changing the profile inputs afterwards has no effect on the running sequence until the next `rate_start`.
- R11: `upd_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_vtotal | input | 16 | Base mode vertical total in lines |
| base_vs_start | input | 16 | Base mode line on which vertical sync starts |
| base_vdisp | input | 16 | Base mode active display lines |
| prof_vtotal | input | 16 | Profile integer vertical total N |
| prof_len | input | 8 | Profile pattern length in frames (0 means no fraction) |
| prof_pattern | input | 128 | Profile pattern, 16 bytes, byte k at [8k+7:8k] |
| rate_start | input | 1 | Pulse that requests a new rate |
| frame_start | input | 1 | Frame-start pulse |
| vtotal_o | output | 16 | Vertical total for the current frame |
| vfp_o | output | 16 | Vertical front porch for the current frame |
| upd_o | output | 1 | One-cycle strobe: new total and porch presented |
| err_o | output | 1 | One-cycle strobe: computed total was zero, change refused |

## Verification
The bench aims at the points where an indexing slip shows up as a wrong total in only a few frames. These are: bit order inside a byte, checked with a known 24-frame pattern (a reversed order gives N+1 on the first frame instead of N); the wrap at the last index (an off-by-one gives a period one frame too long or too short); and a length above 128, where a missing clamp would read past the pattern. It also covers a zero length, which would keep stepping if the active flag were set wrongly, and a zero total. In the zero-total case, a design that cleared the pending flag would never retry, and one that wrote the output would present a zero total. Finally, the bench changes the profile during a running sequence. A design that did not capture the profile would follow the new inputs at once.

// File: rtl/vtf_pkg.sv
package vtf_pkg;
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_START = 2'd1,
    EV_STEP  = 2'd2
  } vtf_ev_e;
endpackage

// File: rtl/vtf_ctrl.sv
module vtf_ctrl
  import vtf_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate_start,
  input  logic          frame_start,
  input  logic          calc_ok,
  input  logic [LW-1:0] len_sel,
  output vtf_ev_e       ev,
  output logic [LW-1:0] idx
);
  logic          pend_q, pend_d;
  logic          act_q, act_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] inc;
  logic          take;

  always_comb begin
    if (frame_start && pend_q)     ev = EV_START;
    else if (frame_start && act_q) ev = EV_STEP;
    else                           ev = EV_IDLE;
  end

  // index used for this frame; a fresh rate always begins at 0
  assign idx  = (ev == EV_START) ? '0 : cnt_q;
  assign inc  = idx + LW'(1);
  assign take = (ev != EV_IDLE) && calc_ok;

  always_comb begin
    pend_d = rate_start | (pend_q & ~((ev == EV_START) && calc_ok));
    act_d  = act_q;
    cnt_d  = cnt_q;
    if (take) begin
      cnt_d = (inc >= len_sel) ? '0 : inc;
      if (ev == EV_START) act_d = (len_sel != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/vtf_patsel.sv
module vtf_patsel #(
  parameter int PAT_BITS = 128,
  parameter int LW       = 8
) (
  input  logic [PAT_BITS-1:0] pattern,
  input  logic [LW-1:0]       idx,
  output logic                bit_o
);
  localparam int IW = $clog2(PAT_BITS);
  logic [PAT_BITS-1:0] lin;

  // remap byte-wise MSB-first storage into a linear frame order
  for (genvar p = 0; p < PAT_BITS; p++) begin : g_map
    assign lin[p] = pattern[8*(p/8) + 7 - (p%8)];
  end

  assign bit_o = (int'(idx) < PAT_BITS) ? lin[idx[IW-1:0]] : 1'b0;
endmodule

// File: rtl/vtf_timing.sv
module vtf_timing #(
  parameter int VW = 16
) (
  input  logic [VW-1:0] int_total,
  input  logic          frac_bit,
  input  logic          frac_on,
  input  logic [VW-1:0] base_vtotal,
  input  logic [VW-1:0] base_vs_start,
  input  logic [VW-1:0] base_vdisp,
  output logic [VW-1:0] total,
  output logic [VW-1:0] fp,
  output logic          ok
);
  logic [VW-1:0] base_fp;

  assign total   = int_total + VW'(frac_on & frac_bit);
  assign base_fp = base_vs_start - base_vdisp;
  assign fp      = base_fp + total - base_vtotal;
  assign ok      = (total != '0);
endmodule

// File: rtl/vtot_frac_seq.sv
module vtot_frac_seq
  import vtf_pkg::*;
#(
  parameter int VW       = 16,
  parameter int LW       = 8,
  parameter int PAT_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VW-1:0]       base_vtotal,
  input  logic [VW-1:0]       base_vs_start,
  input  logic [VW-1:0]       base_vdisp,
  input  logic [VW-1:0]       prof_vtotal,
  input  logic [LW-1:0]       prof_len,
  input  logic [PAT_BITS-1:0] prof_pattern,
  input  logic                rate_start,
  input  logic                frame_start,
  output logic [VW-1:0]       vtotal_o,
  output logic [VW-1:0]       vfp_o,
  output logic                upd_o,
  output logic                err_o
);
  localparam logic [LW-1:0] MAX_LEN = LW'(PAT_BITS);

  vtf_ev_e             ev;
  logic [LW-1:0]       idx;
  logic [LW-1:0]       len_in, len_sel, len_q;
  logic [VW-1:0]       int_sel, int_q;
  logic [PAT_BITS-1:0] pat_sel, pat_q;
  logic                fbit, ok;
  logic [VW-1:0]       total, fp;
  logic                is_start, prof_en, out_en;
  logic [VW-1:0]       vt_d, fp_d;
  logic                upd_d, err_d;

  assign len_in   = (prof_len > MAX_LEN) ? MAX_LEN : prof_len;
  assign is_start = (ev == EV_START);
  assign len_sel  = is_start ? len_in      : len_q;
  assign int_sel  = is_start ? prof_vtotal : int_q;
  assign pat_sel  = is_start ? prof_pattern : pat_q;

  vtf_ctrl #(.LW(LW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .rate_start(rate_start),
    .frame_start(frame_start), .calc_ok(ok), .len_sel(len_sel),
    .ev(ev), .idx(idx)
  );

  vtf_patsel #(.PAT_BITS(PAT_BITS), .LW(LW)) i_patsel (
    .pattern(pat_sel), .idx(idx), .bit_o(fbit)
  );

  vtf_timing #(.VW(VW)) i_timing (
    .int_total(int_sel), .frac_bit(fbit), .frac_on(len_sel != '0),
    .base_vtotal(base_vtotal), .base_vs_start(base_vs_start),
    .base_vdisp(base_vdisp), .total(total), .fp(fp), .ok(ok)
  );

  assign prof_en = is_start && ok;
  assign out_en  = (ev != EV_IDLE) && ok;

  always_comb begin
    vt_d  = out_en ? total : vtotal_o;
    fp_d  = out_en ? fp    : vfp_o;
    upd_d = out_en;
    err_d = (ev != EV_IDLE) && !ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      int_q <= '0;
      pat_q <= '0;
    end else if (prof_en) begin
      len_q <= len_in;
      int_q <= prof_vtotal;
      pat_q <= prof_pattern;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtotal_o <= '0;
      vfp_o    <= '0;
      upd_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      vtotal_o <= vt_d;
      vfp_o    <= fp_d;
      upd_o    <= upd_d;
      err_o    <= err_d;
    end
  end
endmodule

// File: rtl/vtf_chk.sv
module vtf_chk #(
  parameter int VW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] base_vtotal,
  input logic [VW-1:0] base_vs_start,
  input logic [VW-1:0] base_vdisp,
  input logic          frame_start,
  input logic [VW-1:0] vtotal_o,
  input logic [VW-1:0] vfp_o,
  input logic          upd_o,
  input logic          err_o
);
  // R2: a strobe only ever follows a frame-start pulse
  p_upd_after_fs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(frame_start));

  // R9: an error strobe also follows a frame start
  p_err_after_fs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(frame_start));

  // R11: update and error exclude each other
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_o && err_o));

  // R9: a presented total is never zero
  p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (vtotal_o != '0));

  // R2: outputs hold between strobes
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> ($stable(vtotal_o) && $stable(vfp_o)));

  // R8: porch tracks the total against the base timing
  p_porch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (vfp_o == VW'($past(base_vs_start) - $past(base_vdisp)
                            + vtotal_o - $past(base_vtotal))));
endmodule

bind vtot_frac_seq vtf_chk #(.VW(VW)) i_vtf_chk (
  .clk(clk), .rst_n(rst_n), .base_vtotal(base_vtotal),
  .base_vs_start(base_vs_start), .base_vdisp(base_vdisp),
  .frame_start(frame_start), .vtotal_o(vtotal_o), .vfp_o(vfp_o),
  .upd_o(upd_o), .err_o(err_o)
);

// File: tb/test_vtot_frac_seq.sv
`timescale 1ns/1ps
module test_vtot_frac_seq;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  base_vtotal, base_vs_start, base_vdisp, prof_vtotal;
  logic [7:0]   prof_len;
  logic [127:0] prof_pattern;
  logic         rate_start, frame_start;
  logic [15:0]  vtotal_o, vfp_o;
  logic         upd_o, err_o;

  int checks = 0;
  int fails  = 0;

  // bench model state
  bit           m_pend, m_act;
  int           m_cnt, m_len;
  logic [15:0]  m_int, m_vt, m_fp;
  logic [127:0] m_pat;

  always #5 clk = ~clk;

  vtot_frac_seq i_vtot_frac_seq (
    .clk(clk), .rst_n(rst_n), .base_vtotal(base_vtotal),
    .base_vs_start(base_vs_start), .base_vdisp(base_vdisp),
    .prof_vtotal(prof_vtotal), .prof_len(prof_len),
    .prof_pattern(prof_pattern), .rate_start(rate_start),
    .frame_start(frame_start), .vtotal_o(vtotal_o), .vfp_o(vfp_o),
    .upd_o(upd_o), .err_o(err_o)
  );

  function automatic bit pbit(logic [127:0] pat, int p);
    return pat[8*(p/8) + 7 - (p%8)];
  endfunction

  function automatic logic [15:0] porch(logic [15:0] t);
    return base_vs_start - base_vdisp + t - base_vtotal;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic pulse_rate();
    @(negedge clk); rate_start = 1'b1;
    @(negedge clk); rate_start = 1'b0;
    m_pend = 1'b1;
  endtask

  // one frame start, then check outputs one cycle later
  task automatic frame(string rq);
    logic [15:0] t;
    bit eu, ee;
    int len, idx;
    eu = 0; ee = 0;
    if (m_pend) begin
      len = (prof_len > 8'd128) ? 128 : int'(prof_len);
      t = prof_vtotal + 16'((len != 0) && pbit(prof_pattern, 0));
      if (t == 0) ee = 1;
      else begin
        eu = 1; m_pend = 0; m_len = len; m_int = prof_vtotal;
        m_pat = prof_pattern; m_act = (len != 0);
        m_cnt = (1 >= len) ? 0 : 1; m_vt = t; m_fp = porch(t);
      end
    end else if (m_act) begin
      idx = m_cnt;
      t = m_int + 16'(pbit(m_pat, idx));
      if (t == 0) ee = 1;
      else begin
        eu = 1; m_vt = t; m_fp = porch(t);
        m_cnt = (idx + 1 >= m_len) ? 0 : idx + 1;
      end
    end
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk({rq, " upd"}, 32'(upd_o), 32'(eu));
    chk({rq, " err"}, 32'(err_o), 32'(ee));
    chk({rq, " vtotal"}, 32'(vtotal_o), 32'(m_vt));
    chk({rq, " vfp"}, 32'(vfp_o), 32'(m_fp));
    @(negedge clk);
    chk({rq, " strobe one cycle R2"}, 32'(upd_o | err_o), 32'd0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; rate_start = 0; frame_start = 0;
    base_vtotal = 16'd750; base_vs_start = 16'd725; base_vdisp = 16'd720;
    prof_vtotal = 16'd750; prof_len = 8'd0; prof_pattern = '0;
    m_pend = 0; m_act = 0; m_cnt = 0; m_len = 0; m_int = 0; m_vt = 0;
    m_fp = 0; m_pat = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 vtotal", 32'(vtotal_o), 0);
    chk("R1 vfp", 32'(vfp_o), 0);
    chk("R1 upd", 32'(upd_o), 0);
    chk("R1 err", 32'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 idle frame start does nothing
    frame("R2 idle");

    // R4 known pattern bytes 0x3f,0xe3,0xfe over 24 frames
    prof_vtotal = 16'd750; prof_len = 8'd24;
    prof_pattern = '0; prof_pattern[23:0] = 24'hfee33f;
    pulse_rate();
    frame("R3 first frame index0");
    chk("R4 frame0 is N", 32'(vtotal_o), 750);
    frame("R4 frame1");
    chk("R4 frame1 is N", 32'(vtotal_o), 750);
    frame("R4 frame2");
    chk("R4 frame2 is N+1", 32'(vtotal_o), 751);
    chk("R8 porch", 32'(vfp_o), 32'(16'd6));
    for (int i = 0; i < 30; i++) frame("R5 wrap 24");

    // R10 changed profile inputs do not disturb the running sequence
    prof_vtotal = 16'd1200; prof_pattern = '1; prof_len = 8'd3;
    for (int i = 0; i < 10; i++) frame("R10 latched profile");

    // R6 zero length: one update then silence
    prof_vtotal = 16'd900; prof_len = 8'd0;
    pulse_rate();
    frame("R6 zero length apply");
    chk("R6 integer total", 32'(vtotal_o), 900);
    frame("R6 no step");
    frame("R6 no step again");

    // R9 zero total refused, then retried
    prof_vtotal = 16'd0; prof_len = 8'd4; prof_pattern = '0;
    pulse_rate();
    frame("R9 zero total");
    chk("R9 output kept", 32'(vtotal_o), 900);
    prof_vtotal = 16'd1125;
    frame("R9 retry");
    chk("R9 retry applied", 32'(vtotal_o), 1125);

    // R7 length above 128 clamps: only bit 127 set
    prof_vtotal = 16'd2250; prof_len = 8'd200; prof_pattern = '0;
    prof_pattern[120] = 1'b1;   // byte 15, MSB-first position 7 -> index 127
    pulse_rate();
    for (int i = 0; i < 130; i++) begin
      frame("R7 clamp");
      if (i == 127) chk("R7 index127 is N+1", 32'(vtotal_o), 2251);
      if (i == 128) chk("R7 wraps to index0", 32'(vtotal_o), 2250);
    end

    // R5 R3 R8 random profiles and base timings
    for (int k = 0; k < 24; k++) begin
      base_vtotal   = 16'(700 + $urandom_range(0, 4000));
      base_vdisp    = 16'(base_vtotal - 40);
      base_vs_start = 16'(base_vdisp + $urandom_range(1, 20));
      prof_vtotal   = 16'(base_vtotal + $urandom_range(0, 3000));
      prof_len      = 8'($urandom_range(0, 140));
      for (int b = 0; b < 4; b++) prof_pattern[32*b +: 32] = $urandom;
      pulse_rate();
      for (int f = 0; f < 2*int'(prof_len) + 3 && f < 150; f++)
        frame("R5 random sequence");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule